// File: doc/BRIEF.md
# SPI EEPROM Page-Write Sequencer

This block is the master side of a serial EEPROM write path. A command port takes a start address and a byte count. The data bytes then arrive on a valid/ready stream. The sequencer writes them to the memory over an SPI link with clock polarity 0 and phase 0. The memory accepts at most one page of 64 bytes per write burst, so the sequencer splits the transfer wherever the address crosses a page boundary. For every page it performs three steps. First, a one-byte write-enable transaction. Second, a write transaction that carries the 16-bit address and the page's share of the data. Third, a series of status reads that repeat until the memory reports its internal programming cycle finished.

Every instruction is framed by its own chip-select low period. The write burst ends by raising chip-select straight after the last data byte, with nothing appended. The memory clears its write-enable latch by itself when programming completes. A write-protect release output is raised for each page write. The serial clock is a fixed division of the system clock, and every output comes from a register.

Top module: `spi_page_writer`

## Requirements
- R1: While reset is asserted and right after it, cs_n is 1, sclk is 0, wp_n is 0, busy, done and in_ready are 0.
- R2: Each page starts with a chip-select frame holding only the byte 0x06. It is followed by a frame holding 0x02, then the address high byte, then the address low byte, then the data bytes.
- R3: The number of data bytes in a page burst is the smaller of (64 minus the address modulo 64) and the bytes still to send. The next burst starts at the address following the last byte written.
- R4: A write frame is exactly 3 plus the burst length bytes long; no byte follows the last data byte.
- R5: After each write frame the block issues status frames of two bytes, the first being 0x05. Only bit 0 of the second byte, as received on miso MSB first, is used. A new status frame follows while that bit is 1, and the block moves on once it is 0.
- R6: Between any two frames cs_n stays high for at least two serial clock periods (4 × SCLK_HALF system clocks).
- R7: sclk is low whenever cs_n is high. mosi does not change while sclk is high. Bytes are shifted MSB first.
- R8: wp_n is 1 during every frame of a page write and is 0 once the final status frame of the command has reported bit 0 clear.
- R9: A start with non-zero length while idle sets busy from the next cycle until the end of the command. done is then a one-cycle pulse with busy low. A start while busy is ignored.
- R10: A start with length 0 produces a done pulse in the next cycle with busy staying low and no chip-select activity.
- R11: in_ready is raised only in the data phase of a write frame. Exactly the requested number of bytes is taken, one per handshake and in arrival order, with any gaps in in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start request, sampled when idle |
| cmd_addr | input | ADDR_W | First memory address of the transfer |
| cmd_len | input | LEN_W | Number of bytes to write |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Data byte accepted this cycle when in_valid is high |
| in_data | input | 8 | Data byte |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_wp_n | output | 1 | Write-protect release, high while a page is being written |

## Verification
The hardest situations to reach from the ports are a status poll that keeps reporting busy and a burst that begins one byte before a page end. Both depend on what the memory answers and on where the address lands. The bench contains a behavioural slave that decodes every chip-select frame. After each write frame it answers a programmable number of status reads with bit 0 set. Its other status bits are always the opposite of bit 0, so a design that looks at the wrong bit gets caught. The directed commands start at offsets 0, 58 and 63 within a page, and one of them throttles in_valid and fires a stray start mid-transfer.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam logic [7:0] OP_WEN  = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h05;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WEN,
        ST_POP,
        ST_AHI,
        ST_ALO,
        ST_DATA,
        ST_SOP,
        ST_SBYTE,
        ST_GAP,
        ST_FIN
    } seq_st_e;

endpackage

// File: rtl/spw_burst_calc.sv
module spw_burst_calc #(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int BURST_W   = OFS_W + 1
) (
    input  logic [OFS_W-1:0]   page_off,
    input  logic [LEN_W-1:0]   remaining,
    output logic [BURST_W-1:0] burst
);

    logic [BURST_W-1:0] room;

    always_comb begin
        room = BURST_W'(PAGE_BYTES) - BURST_W'(page_off);
        if (remaining < LEN_W'(room)) begin
            burst = BURST_W'(remaining);
        end else begin
            burst = room;
        end
    end

endmodule

// File: rtl/spw_byte_engine.sv
module spw_byte_engine #(
    parameter int SCLK_HALF = 2,
    localparam int DIV_W    = $clog2(SCLK_HALF + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       rx_last,
    output logic       done
);

    typedef struct packed {
        logic             busy;
        logic [DIV_W-1:0] div;
        logic [2:0]       bitn;
        logic             hi;
        logic [7:0]       sh;
        logic             sclk;
        logic             rx;
        logic             done;
    } eng_t;

    eng_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.busy) begin
            if (go) begin
                n.busy = 1'b1;
                n.sh   = tx_byte;
                n.div  = '0;
                n.bitn = '0;
                n.hi   = 1'b0;
                n.sclk = 1'b0;
            end
        end else if (q.div == DIV_W'(SCLK_HALF - 1)) begin
            n.div = '0;
            if (!q.hi) begin
                n.sclk = 1'b1;
                n.hi   = 1'b1;
                n.rx   = miso;
            end else begin
                n.sclk = 1'b0;
                n.hi   = 1'b0;
                if (q.bitn == 3'd7) begin
                    n.busy = 1'b0;
                    n.done = 1'b1;
                end else begin
                    n.bitn = q.bitn + 3'd1;
                    n.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            n.div = q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign sclk    = q.sclk;
    assign mosi    = q.sh[7];
    assign rx_last = q.rx;
    assign done    = q.done;

    // R7: data line held steady through the high half of each clock
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(q.sh[7]));

endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 16,
    parameter int PAGE_BYTES  = 64,
    parameter int SCLK_HALF   = 2,
    parameter int CS_GAP_SCLK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_busy,
    output logic              cmd_done,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic              spi_wp_n
);
    import spw_pkg::*;

    localparam int OFS_W   = $clog2(PAGE_BYTES);
    localparam int BURST_W = OFS_W + 1;
    localparam int GAP_CYC = CS_GAP_SCLK * 2 * SCLK_HALF;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_st_e            st;
        seq_st_e            after_gap;
        logic [GAP_W-1:0]   gap_cnt;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   left;
        logic [BURST_W-1:0] burst;
        logic               inflight;
        logic               cs_n;
        logic               wp;
        logic               busy;
        logic               done;
        logic               rdy;
    } seq_t;

    seq_t q, n;

    logic               eng_go;
    logic [7:0]         eng_tx;
    logic               eng_done;
    logic               eng_rx;
    logic [BURST_W-1:0] burst_w;
    logic [15:0]        addr16;
    logic               cmd_byte;

    spw_burst_calc #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_calc (
        .page_off  (q.addr[OFS_W-1:0]),
        .remaining (q.left),
        .burst     (burst_w)
    );

    spw_byte_engine #(
        .SCLK_HALF (SCLK_HALF)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_last (eng_rx),
        .done    (eng_done)
    );

    assign addr16 = 16'(q.addr);

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        eng_go   = 1'b0;
        eng_tx   = 8'h00;
        cmd_byte = 1'b0;

        case (q.st)
            ST_WEN:   begin eng_tx = OP_WEN;        cmd_byte = 1'b1; end
            ST_POP:   begin eng_tx = OP_PROG;       cmd_byte = 1'b1; end
            ST_AHI:   begin eng_tx = addr16[15:8];  cmd_byte = 1'b1; end
            ST_ALO:   begin eng_tx = addr16[7:0];   cmd_byte = 1'b1; end
            ST_SOP:   begin eng_tx = OP_STAT;       cmd_byte = 1'b1; end
            ST_SBYTE: begin eng_tx = 8'h00;         cmd_byte = 1'b1; end
            default:  begin eng_tx = in_data;       cmd_byte = 1'b0; end
        endcase

        if (cmd_byte && !q.inflight) begin
            eng_go     = 1'b1;
            n.inflight = 1'b1;
            n.cs_n     = 1'b0;
        end

        case (q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    if (cmd_len == '0) begin
                        n.done = 1'b1;
                    end else begin
                        n.addr = cmd_addr;
                        n.left = cmd_len;
                        n.busy = 1'b1;
                        n.st   = ST_WEN;
                    end
                end
            end
            ST_WEN: begin
                if (!q.inflight) begin
                    n.wp    = 1'b1;
                    n.burst = burst_w;
                end else if (eng_done) begin
                    n.inflight  = 1'b0;
                    n.cs_n      = 1'b1;
                    n.gap_cnt   = '0;
                    n.after_gap = ST_POP;
                    n.st        = ST_GAP;
                end
            end
            ST_POP, ST_AHI: begin
                if (q.inflight && eng_done) begin
                    n.inflight = 1'b0;
                    n.st       = (q.st == ST_POP) ? ST_AHI : ST_ALO;
                end
            end
            ST_ALO: begin
                if (q.inflight && eng_done) begin
                    n.inflight = 1'b0;
                    n.rdy      = 1'b1;
                    n.st       = ST_DATA;
                end
            end
            ST_DATA: begin
                if (q.inflight) begin
                    if (eng_done) begin
                        n.inflight = 1'b0;
                        n.addr     = q.addr + ADDR_W'(1);
                        n.left     = q.left - LEN_W'(1);
                        n.burst    = q.burst - BURST_W'(1);
                        if (q.burst == BURST_W'(1)) begin
                            n.cs_n      = 1'b1;
                            n.gap_cnt   = '0;
                            n.after_gap = ST_SOP;
                            n.st        = ST_GAP;
                        end else begin
                            n.rdy = 1'b1;
                        end
                    end
                end else if (q.rdy && in_valid) begin
                    eng_go     = 1'b1;
                    n.inflight = 1'b1;
                    n.rdy      = 1'b0;
                end
            end
            ST_SOP: begin
                if (q.inflight && eng_done) begin
                    n.inflight = 1'b0;
                    n.st       = ST_SBYTE;
                end
            end
            ST_SBYTE: begin
                if (q.inflight && eng_done) begin
                    n.inflight = 1'b0;
                    n.cs_n     = 1'b1;
                    n.gap_cnt  = '0;
                    n.st       = ST_GAP;
                    if (eng_rx) begin
                        n.after_gap = ST_SOP;
                    end else begin
                        n.wp        = 1'b0;
                        n.after_gap = (q.left == '0) ? ST_FIN : ST_WEN;
                    end
                end
            end
            ST_GAP: begin
                n.gap_cnt = q.gap_cnt + GAP_W'(1);
                if (q.gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                    n.st = q.after_gap;
                end
            end
            ST_FIN: begin
                n.busy = 1'b0;
                n.done = 1'b1;
                n.st   = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign cmd_busy = q.busy;
    assign cmd_done = q.done;
    assign in_ready = q.rdy;
    assign spi_cs_n = q.cs_n;
    assign spi_wp_n = q.wp;

    // Cycles chip-select has been high, saturating, used by p_cs_gap_r6
    logic [GAP_W-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= GAP_W'(GAP_CYC);
        end else if (!q.cs_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != GAP_W'(GAP_CYC)) begin
            hi_cnt_q <= hi_cnt_q + GAP_W'(1);
        end
    end

    p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) |-> (hi_cnt_q >= GAP_W'(GAP_CYC)));

    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs_n |-> !spi_sclk);

    p_wp_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cs_n |-> q.wp);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !q.busy && cmd_len != '0) |=> q.busy);

    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !q.busy && cmd_len == '0) |=> (q.done && !q.busy));

    p_ready_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |-> (q.st == ST_DATA && !q.inflight));

    p_burst_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WEN && !q.inflight) |->
        (burst_w != '0 && LEN_W'(burst_w) <= q.left &&
         (32'(q.addr[OFS_W-1:0]) + 32'(burst_w)) <= PAGE_BYTES));

endmodule

// File: tb/tb_spi_page_writer.sv
module tb_spi_page_writer;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_busy, cmd_done;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        spi_sclk, spi_mosi, spi_cs_n, spi_wp_n;
    logic        spi_miso = 1'b0;

    spi_page_writer #(
        .ADDR_W (16), .LEN_W (16), .PAGE_BYTES (64),
        .SCLK_HALF (HALF), .CS_GAP_SCLK (2)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_start (cmd_start), .cmd_addr (cmd_addr), .cmd_len (cmd_len),
        .cmd_busy (cmd_busy), .cmd_done (cmd_done),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .spi_sclk (spi_sclk), .spi_mosi (spi_mosi), .spi_miso (spi_miso),
        .spi_cs_n (spi_cs_n), .spi_wp_n (spi_wp_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [7:0] log_b [0:4095];
    int  fr_start [0:511];
    int  fr_len   [0:511];
    int  fr_wp    [0:511];
    int  fr_cnt = 0, byte_ptr = 0;
    int  cfg_polls = 0, poll_left = 0;
    int  hi_cnt = 0, min_gap = 1000000, mode_err = 0;
    logic cs_prev = 1'b1, sclk_prev = 1'b0, mosi_prev = 1'b0;
    logic [7:0]  sl_sh = '0;
    int          sl_bits = 0;
    logic [15:0] out_sr = '0;

    always @(negedge clk) begin
        if (cs_prev && !spi_cs_n) begin
            if (fr_cnt > 0 && hi_cnt < min_gap) min_gap = hi_cnt;
            fr_start[fr_cnt] = byte_ptr;
            fr_len[fr_cnt]   = 0;
            fr_wp[fr_cnt]    = int'(spi_wp_n);
            sl_bits = 0;
            out_sr  = {8'h00, (poll_left > 0) ? 8'h01 : 8'hFE};
            spi_miso = out_sr[15];
        end
        if (!spi_cs_n) begin
            if (spi_sclk && !sclk_prev) begin
                sl_sh = {sl_sh[6:0], spi_mosi};
                sl_bits++;
                if (sl_bits == 8) begin
                    if (byte_ptr < 4095) begin
                        log_b[byte_ptr] = sl_sh;
                        byte_ptr++;
                    end
                    fr_len[fr_cnt]++;
                    sl_bits = 0;
                end
            end
            if (!spi_sclk && sclk_prev) begin
                out_sr   = out_sr << 1;
                spi_miso = out_sr[15];
            end
            if (spi_sclk && sclk_prev && spi_mosi !== mosi_prev) mode_err++;
        end else if (spi_sclk) begin
            mode_err++;
        end
        if (!cs_prev && spi_cs_n) begin
            if (fr_len[fr_cnt] > 0) begin
                if (log_b[fr_start[fr_cnt]] == 8'h02) poll_left = cfg_polls;
                else if (log_b[fr_start[fr_cnt]] == 8'h05 && poll_left > 0) poll_left--;
            end
            if (fr_cnt < 511) fr_cnt++;
            hi_cnt = 0;
        end
        if (spi_cs_n) hi_cnt++;
        cs_prev   = spi_cs_n;
        sclk_prev = spi_sclk;
        mosi_prev = spi_mosi;
    end

    // ---------------- data source ----------------
    int feed_idx = 0, feed_len = 0, feed_seed = 0, tick = 0;
    bit feed_stall = 1'b0, hs_pend = 1'b0;

    function automatic logic [7:0] dat(input int seed, input int i);
        return 8'((seed + 37 * i) ^ (i >> 3));
    endfunction

    always @(negedge clk) begin
        tick++;
        if (hs_pend) feed_idx++;
        in_valid = (feed_idx < feed_len) && !(feed_stall && (tick % 3 == 1));
        in_data  = dat(feed_seed, feed_idx);
        hs_pend  = in_valid && in_ready;
    end

    // ---------------- frame checker ----------------
    task automatic verify_frames(input int a0, input int n, input int seed, input int polls);
        int f = 0, a = a0, rem = n, di = 0;
        while (rem > 0 && f < 500) begin
            int b = 64 - (a % 64);
            int mm = 0;
            if (rem < b) b = rem;
            chk(fr_len[f] == 1, "R2 enable frame length", fr_len[f], 1);
            chk(log_b[fr_start[f]] == 8'h06, "R2 enable opcode", log_b[fr_start[f]], 8'h06);
            chk(fr_wp[f] == 1, "R8 wp in enable frame", fr_wp[f], 1);
            f++;
            chk(fr_len[f] == 3 + b, "R3 R4 write frame length", fr_len[f], 3 + b);
            chk(log_b[fr_start[f]] == 8'h02, "R2 write opcode", log_b[fr_start[f]], 8'h02);
            chk(log_b[fr_start[f] + 1] == 8'((a >> 8) & 255), "R2 address high",
                log_b[fr_start[f] + 1], (a >> 8) & 255);
            chk(log_b[fr_start[f] + 2] == 8'(a & 255), "R2 address low",
                log_b[fr_start[f] + 2], a & 255);
            for (int j = 0; j < b; j++)
                if (log_b[fr_start[f] + 3 + j] != dat(seed, di + j)) mm++;
            chk(mm == 0, "R11 data bytes in order", mm, 0);
            chk(fr_wp[f] == 1, "R8 wp in write frame", fr_wp[f], 1);
            f++;
            for (int p = 0; p <= polls; p++) begin
                chk(fr_len[f] == 2 && log_b[fr_start[f]] == 8'h05, "R5 status frame",
                    {fr_len[f][7:0], log_b[fr_start[f]]}, 16'h0205);
                chk(fr_wp[f] == 1, "R8 wp in status frame", fr_wp[f], 1);
                f++;
            end
            a += b; rem -= b; di += b;
        end
        chk(fr_cnt == f, "R5 frame count per command", fr_cnt, f);
    endtask

    task automatic run_cmd(input int a, input int n, input int seed, input int polls,
                           input bit stall, input bit poke);
        int cyc = 0;
        bit drop = 1'b0;
        fr_cnt = 0; byte_ptr = 0; cfg_polls = polls; poll_left = 0;
        min_gap = 1000000; mode_err = 0;
        feed_len = n; feed_seed = seed; feed_stall = stall;
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = 16'(a); cmd_len = 16'(n);
        @(negedge clk);
        cmd_start = 1'b0;
        chk(cmd_busy == 1'b1, "R9 busy after start", cmd_busy, 1);
        while (!cmd_done) begin
            @(negedge clk);
            cyc++;
            if (!cmd_busy && !cmd_done) drop = 1'b1;
            if (poke && cyc == 300) begin
                cmd_start = 1'b1; cmd_addr = 16'h0000; cmd_len = 16'd3;
            end else begin
                cmd_start = 1'b0;
            end
        end
        chk(cmd_busy == 1'b0, "R9 busy low at done", cmd_busy, 0);
        chk(!drop, "R9 busy held until done", drop, 0);
        chk(spi_wp_n == 1'b0, "R8 wp low after completion", spi_wp_n, 0);
        @(negedge clk);
        chk(cmd_done == 1'b0, "R9 done single pulse", cmd_done, 0);
        chk(feed_idx == n, "R11 bytes consumed", feed_idx, n);
        verify_frames(a, n, seed, polls);
        chk(mode_err == 0, "R7 clock and data timing", mode_err, 0);
        chk(min_gap >= 4 * HALF, "R6 chip-select high gap", min_gap, 4 * HALF);
        feed_len = 0;
        @(negedge clk);
        feed_idx = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_wp_n == 1'b0, "R1 pins in reset",
            {spi_cs_n, spi_sclk, spi_wp_n}, 3'b100);
        chk(!cmd_busy && !cmd_done && !in_ready, "R1 flags in reset",
            {cmd_busy, cmd_done, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && !cmd_busy && !in_ready, "R1 after reset",
            {spi_cs_n, cmd_busy, in_ready}, 3'b100);
    endtask

    task automatic t_zero_len;
        fr_cnt = 0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = 16'h0123; cmd_len = 16'd0;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(cmd_done == 1'b1 && cmd_busy == 1'b0, "R10 immediate done",
            {cmd_done, cmd_busy}, 2'b10);
        @(negedge clk);
        chk(cmd_done == 1'b0, "R10 done single pulse", cmd_done, 0);
        repeat (20) @(negedge clk);
        chk(fr_cnt == 0 && spi_cs_n == 1'b1, "R10 no chip-select activity", fr_cnt, 0);
    endtask

    task automatic t_aligned_polls;  // R2 R4 R5 R7 R8
        run_cmd(16'h0000, 8, 3, 3, 1'b0, 1'b0);
    endtask

    task automatic t_cross_page;     // R3: offset 58 gives 6 then 4
        run_cmd(16'h013A, 10, 91, 0, 1'b0, 1'b0);
    endtask

    task automatic t_multi_stall;    // R3 R11 R9 stray start ignored
        run_cmd(16'h0040, 130, 200, 1, 1'b1, 1'b1);
    endtask

    task automatic t_last_byte;      // R3: offset 63 gives bursts of 1 and 1
        run_cmd(16'h3FFF, 2, 17, 2, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_zero_len();
        t_aligned_polls();
        t_cross_page();
        t_multi_stall();
        t_last_byte();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule